// File: doc/BRIEF.md
# Sixty-Four Source Vectored Interrupt Controller

The block gathers up to 64 active-low interrupt requests and reduces them to a single interrupt line for the CPU, together with a vector word that names the source to service. Each request line passes through a two-flop synchronizer. A fixed set of lines can then be switched between low-level sensing and falling-edge sensing. Requests are latched into pending bits, which software clears by writing ones, and are gated by per-source enable bits.

Pending and enable state live in two 32-bit words, an upper and a lower one. Source numbers do not map arithmetically onto word bits. Software works out the bit position from a fixed scatter rule, and the hardware uses the same rule. The CPU reads the vector word to learn the winning source, then clears its pending bit.

The register port is a plain synchronous bus. A write takes effect on the clock edge where `sel_i` and `wr_i` are both high. Read data is a combinational function of `addr_i` and the stored state. Two priority words and a 16-bit configuration word are kept as plain storage and have no effect on selection.

Top module: `irq_vec_ctl`

## Requirements
- R1: After reset, both enable words, both pending words and the sense word read 0. Both priority words (addresses 6 and 7) read 0x05309770, the configuration word (address 8) reads 0, `irq_o` is low and the vector word reads 0.
- R2: Register addresses are 0 enable-upper, 1 enable-lower, 2 pending-upper, 3 pending-lower, 4 vector (read only), 5 sense, 6 and 7 priority, 8 configuration. An unmapped address reads 0.
- R3: Sources 0–15 and 32–47 live in the upper word, and sources 16–31 and 48–63 live in the lower word. Bit positions follow these rules:
  - Source 0 uses bit 0, and source s in 1–15 uses bit 16−s.
  - Sources 16–18 use bits 2, 1 and 0. Source s in 19–30 uses bit 33−s. Source 31 uses bit 0.
  - Source s in 32–47 uses bit 63−s.
  - Source s in 48–63 uses bit s−32.
- R4: Writing a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged. A pending bit, once set, stays set until it is cleared this way.
- R5: A source takes part only while its enable bit is 1. `irq_o` is high exactly when some source has both its pending bit and its enable bit set. A pending but disabled source leaves `irq_o` low and the vector at 0.
- R6: The vector word carries, in bits 31:26, the lowest-numbered source that is both pending and enabled. Its bits 25:0 are always 0, and it reads 0 when nothing qualifies. Source 0 therefore also reads as 0, and only `irq_o` tells it apart.
- R7: A line in edge mode sets its pending bit once per high-to-low transition. Holding it low after a clear does not set the bit again. A line in level mode sets its pending bit in every cycle the line is low, so a clear while the line is held low does not last.
- R8: Sense-word bit 33−s selects the mode of external source s in 19–25 (bits 14 down to 8). Bit 79−s selects the mode of port source s in 48–63 (bits 31 down to 16). A 1 selects falling edge and a 0 selects low level.
- R9: Every source not covered by R8 is always level sensed, whatever the sense word holds. No line responds to a rising edge.
- R10: When a request sets a pending bit in the same cycle that a write clears it, the bit ends up set.
- R11: Reading the vector word or any other register changes no state.
- R12: Sources 18 and 31 share bit 0 of the lower word. A request from either sets that bit, and the vector then reports 18.
- R13: A request line driven low is seen in the pending word three clock edges later: two for synchronization and one for latching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_ni | input | 64 | Active-low interrupt request lines, indexed by source number |
| sel_i | input | 1 | Bus access select |
| wr_i | input | 1 | Write strobe; meaningful with sel_i |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request to the CPU, active high |

## Verification
The mapping is tried by pulsing one source at a time across a table of sources, with every source enabled. Each entry sits at a rule boundary: 0, 1, 15, 16, 18, 19, 30, 31, 32, 47, 48 and 63. This separates a wrong word choice from a wrong bit formula, and it also exposes the shared bit through source 31 reporting 18. Held-low lines are then cleared and observed again in edge mode, in level mode and on a fixed-level line with every sense bit set, which separates the edge detector from the level path and a stray sense decode. Paired requests separate lowest-number selection from the reverse order. A clear issued while a level line is low separates set-wins from clear-wins in the very next cycle.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int NSRC   = 64;
    localparam int WORD_W = 32;
    localparam int VEC_W  = 6;
    localparam int REG_AW = 4;
    localparam int CFG_W  = 16;

    localparam logic [REG_AW-1:0] RA_EN_HI   = 4'd0;
    localparam logic [REG_AW-1:0] RA_EN_LO   = 4'd1;
    localparam logic [REG_AW-1:0] RA_PEND_HI = 4'd2;
    localparam logic [REG_AW-1:0] RA_PEND_LO = 4'd3;
    localparam logic [REG_AW-1:0] RA_VECTOR  = 4'd4;
    localparam logic [REG_AW-1:0] RA_SENSE   = 4'd5;
    localparam logic [REG_AW-1:0] RA_PRIO_A  = 4'd6;
    localparam logic [REG_AW-1:0] RA_PRIO_B  = 4'd7;
    localparam logic [REG_AW-1:0] RA_CFG     = 4'd8;

    typedef struct packed {
        logic [2*WORD_W-1:0] en;
        logic [2*WORD_W-1:0] pend;
        logic [WORD_W-1:0]   sense;
        logic [WORD_W-1:0]   prio_a;
        logic [WORD_W-1:0]   prio_b;
        logic [CFG_W-1:0]    cfg;
    } regs_t;

    // Upper word holds sources 0-15 and 32-47.
    function automatic bit src_in_upper(int s);
        return ((s / 16) % 2) == 0;
    endfunction

    // Bit position of a source inside its word.
    function automatic int src_bitpos(int s);
        if (s == 0)       return 0;
        else if (s < 16)  return 16 - s;
        else if (s < 19)  return 18 - s;
        else if (s < 31)  return 33 - s;
        else if (s == 31) return 0;
        else if (s < 48)  return 63 - s;
        else              return s - 32;
    endfunction

    // Flat index: upper word at [63:32], lower word at [31:0].
    function automatic int src_index(int s);
        return (src_in_upper(s) ? WORD_W : 0) + src_bitpos(s);
    endfunction

    // Sense-word bit for a programmable source, -1 when fixed level.
    function automatic int sense_pos(int s);
        if (s >= 19 && s <= 25)      return 33 - s;
        else if (s >= 48 && s <= 63) return 79 - s;
        else                         return -1;
    endfunction

endpackage

// File: rtl/irq_sense_front.sv
module irq_sense_front
    import irq_vec_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NSRC-1:0]     src_ni,
    input  logic [WORD_W-1:0]   sense_i,
    output logic [2*WORD_W-1:0] set_o
);

    typedef struct packed {
        logic [NSRC-1:0] meta;
        logic [NSRC-1:0] sync;
        logic [NSRC-1:0] prev;
    } front_t;

    front_t st_d, st_q;
    logic [NSRC-1:0] edge_mode;
    logic [NSRC-1:0] hit;

    // Sense bits 7:0 and 15 select nothing.
    logic unused_sense;
    assign unused_sense = ^{sense_i[7:0], sense_i[15]};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam int SP = sense_pos(g);
        if (SP >= 0) begin : g_prog
            assign edge_mode[g] = sense_i[SP];
        end else begin : g_fixed
            assign edge_mode[g] = 1'b0;
        end
        assign hit[g] = edge_mode[g] ? (st_q.prev[g] & ~st_q.sync[g])
                                     : ~st_q.sync[g];
    end

    always_comb begin
        st_d      = st_q;
        st_d.meta = src_ni;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
        set_o     = '0;
        for (int s = 0; s < NSRC; s++) begin
            set_o[src_index(s)] = set_o[src_index(s)] | hit[s];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{meta: '1, sync: '1, prev: '1};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_vec_pkg::*;
#(
    parameter logic [WORD_W-1:0] PRIO_RST = 32'h0530_9770
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                we_i,
    input  logic [REG_AW-1:0]   addr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    input  logic [2*WORD_W-1:0] set_i,
    output regs_t               regs_o
);

    regs_t r_d, r_q;
    logic [2*WORD_W-1:0] clr;

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (we_i) begin
            case (addr_i)
                RA_EN_HI:   r_d.en[2*WORD_W-1:WORD_W] = wdata_i;
                RA_EN_LO:   r_d.en[WORD_W-1:0]        = wdata_i;
                RA_PEND_HI: clr[2*WORD_W-1:WORD_W]    = wdata_i;
                RA_PEND_LO: clr[WORD_W-1:0]           = wdata_i;
                RA_SENSE:   r_d.sense                 = wdata_i;
                RA_PRIO_A:  r_d.prio_a                = wdata_i;
                RA_PRIO_B:  r_d.prio_b                = wdata_i;
                RA_CFG:     r_d.cfg                   = wdata_i[CFG_W-1:0];
                default:    ;
            endcase
        end
        // A new request overrides a clear in the same cycle.
        r_d.pend = (r_q.pend & ~clr) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{en: '0, pend: '0, sense: '0,
                     prio_a: PRIO_RST, prio_b: PRIO_RST, cfg: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign regs_o = r_q;

endmodule

// File: rtl/irq_vector_pick.sv
module irq_vector_pick
    import irq_vec_pkg::*;
(
    input  logic [2*WORD_W-1:0] pend_i,
    input  logic [2*WORD_W-1:0] en_i,
    output logic [VEC_W-1:0]    vec_o,
    output logic                any_o
);

    logic [2*WORD_W-1:0] act;
    logic unused_gap;

    assign act        = pend_i & en_i;
    assign unused_gap = act[15];

    // Scan downwards so the lowest-numbered source is assigned last.
    always_comb begin
        vec_o = '0;
        any_o = 1'b0;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (act[src_index(s)]) begin
                vec_o = VEC_W'(s);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl
    import irq_vec_pkg::*;
#(
    parameter logic [WORD_W-1:0] PRIO_RST = 32'h0530_9770
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   src_ni,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int VEC_LSB = WORD_W - VEC_W;

    regs_t               regs;
    logic [2*WORD_W-1:0] set_bits;
    logic [2*WORD_W-1:0] mask_q;
    logic [2*WORD_W-1:0] pend_q;
    logic [VEC_W-1:0]    vec_num;
    logic                any_act;
    logic                we;

    assign we     = sel_i & wr_i;
    assign mask_q = regs.en;
    assign pend_q = regs.pend;

    irq_sense_front u_front (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .src_ni  (src_ni),
        .sense_i (regs.sense),
        .set_o   (set_bits)
    );

    irq_regfile #(.PRIO_RST(PRIO_RST)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .set_i   (set_bits),
        .regs_o  (regs)
    );

    irq_vector_pick u_pick (
        .pend_i (pend_q),
        .en_i   (mask_q),
        .vec_o  (vec_num),
        .any_o  (any_act)
    );

    assign irq_o = any_act;

    always_comb begin
        case (addr_i)
            RA_EN_HI:   rdata_o = mask_q[2*WORD_W-1:WORD_W];
            RA_EN_LO:   rdata_o = mask_q[WORD_W-1:0];
            RA_PEND_HI: rdata_o = pend_q[2*WORD_W-1:WORD_W];
            RA_PEND_LO: rdata_o = pend_q[WORD_W-1:0];
            RA_VECTOR:  rdata_o = {vec_num, {VEC_LSB{1'b0}}};
            RA_SENSE:   rdata_o = regs.sense;
            RA_PRIO_A:  rdata_o = regs.prio_a;
            RA_PRIO_B:  rdata_o = regs.prio_b;
            RA_CFG:     rdata_o = {{(WORD_W-CFG_W){1'b0}}, regs.cfg};
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_vec_ctl_chk.sv
module irq_vec_ctl_chk
    import irq_vec_pkg::*;
(
    input logic                clk_i,
    input logic                rst_ni,
    input logic                sel_i,
    input logic                wr_i,
    input logic [REG_AW-1:0]   addr_i,
    input logic [WORD_W-1:0]   wdata_i,
    input logic                irq_o,
    input logic [2*WORD_W-1:0] mask_q,
    input logic [2*WORD_W-1:0] pend_q,
    input logic [2*WORD_W-1:0] set_bits,
    input logic [VEC_W-1:0]    vec_num
);

    a_r5_irq_needs_enabled_pending: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((pend_q & mask_q) != '0));

    a_r6_idle_vector_zero: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> (vec_num == '0));

    a_r4_w1c_clears_upper: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i && addr_i == RA_PEND_HI) |=>
        ((pend_q[2*WORD_W-1:WORD_W] & $past(wdata_i)
          & ~$past(set_bits[2*WORD_W-1:WORD_W])) == '0));

    a_r10_set_wins: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        (set_bits != '0) |=> ((pend_q & $past(set_bits)) == $past(set_bits)));

    a_r5_enable_only_by_write: assert property (
        @(posedge clk_i) disable iff (!rst_ni)
        !(sel_i && wr_i && (addr_i == RA_EN_HI || addr_i == RA_EN_LO)) |=>
        $stable(mask_q));

endmodule

bind irq_vec_ctl irq_vec_ctl_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .irq_o    (irq_o),
    .mask_q   (mask_q),
    .pend_q   (pend_q),
    .set_bits (set_bits),
    .vec_num  (vec_num)
);

// File: tb/irq_vec_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_vec_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_n = '1;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_vec_ctl dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .src_ni  (src_n),
        .sel_i   (sel),
        .wr_i    (wr),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    typedef struct packed {
        logic [5:0] src;
        logic       upper;
        logic [4:0] bitp;
        logic [5:0] vec;
    } row_t;

    localparam int NROW = 12;
    localparam row_t TBL [NROW] = '{
        '{6'd0,  1'b1, 5'd0,  6'd0 },
        '{6'd1,  1'b1, 5'd15, 6'd1 },
        '{6'd15, 1'b1, 5'd1,  6'd15},
        '{6'd16, 1'b0, 5'd2,  6'd16},
        '{6'd18, 1'b0, 5'd0,  6'd18},
        '{6'd19, 1'b0, 5'd14, 6'd19},
        '{6'd30, 1'b0, 5'd3,  6'd30},
        '{6'd31, 1'b0, 5'd0,  6'd18},
        '{6'd32, 1'b1, 5'd31, 6'd32},
        '{6'd47, 1'b1, 5'd16, 6'd47},
        '{6'd48, 1'b0, 5'd16, 6'd48},
        '{6'd63, 1'b0, 5'd31, 6'd63}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic pulse(input int s);
        @(negedge clk);
        src_n[s] = 1'b0;
        wait_clk(4);
        src_n[s] = 1'b1;
        wait_clk(4);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] d2;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(1);

        // R1 / R2: reset values at every address
        bus_rd(4'd0, d); chk("R1 enable upper", d, 32'h0);
        bus_rd(4'd1, d); chk("R1 enable lower", d, 32'h0);
        bus_rd(4'd2, d); chk("R1 pending upper", d, 32'h0);
        bus_rd(4'd3, d); chk("R1 pending lower", d, 32'h0);
        bus_rd(4'd4, d); chk("R1 vector", d, 32'h0);
        bus_rd(4'd5, d); chk("R1 sense", d, 32'h0);
        bus_rd(4'd6, d); chk("R1 priority a", d, 32'h0530_9770);
        bus_rd(4'd7, d); chk("R1 priority b", d, 32'h0530_9770);
        bus_rd(4'd8, d); chk("R1 config", d, 32'h0);
        chk("R1 irq low", {31'b0, irq}, 32'h0);
        bus_rd(4'd12, d); chk("R2 unmapped reads zero", d, 32'h0);
        bus_wr(4'd8, 32'hFFFF_ABCD);
        bus_rd(4'd8, d); chk("R2 config width", d, 32'h0000_ABCD);
        bus_wr(4'd8, 32'h0);

        // R13: latency of a level request
        @(negedge clk);
        src_n[5] = 1'b0;
        wait_clk(2);
        bus_rd(4'd2, d); chk("R13 not seen after two edges", d, 32'h0);
        wait_clk(1);
        bus_rd(4'd2, d); chk("R13 seen after three edges", d, 32'h1 << 11);
        // R10: clear while the level line is still low
        bus_wr(4'd2, 32'h1 << 11);
        bus_rd(4'd2, d); chk("R10 set wins over clear", d, 32'h1 << 11);
        src_n[5] = 1'b1;
        wait_clk(4);
        bus_wr(4'd2, 32'hFFFF_FFFF);
        bus_rd(4'd2, d); chk("R4 clear after release", d, 32'h0);

        // R3 / R6 / R12: mapping table with everything enabled
        bus_wr(4'd0, 32'hFFFF_FFFF);
        bus_wr(4'd1, 32'hFFFF_FFFF);
        for (int i = 0; i < NROW; i++) begin
            pulse(int'(TBL[i].src));
            bus_rd(TBL[i].upper ? 4'd2 : 4'd3, d);
            chk($sformatf("R3 source %0d own word", TBL[i].src), d, 32'h1 << TBL[i].bitp);
            bus_rd(TBL[i].upper ? 4'd3 : 4'd2, d);
            chk($sformatf("R3 source %0d other word", TBL[i].src), d, 32'h0);
            bus_rd(4'd4, d);
            chk($sformatf("R6 R12 vector for source %0d", TBL[i].src), d, {TBL[i].vec, 26'b0});
            chk($sformatf("R5 irq for source %0d", TBL[i].src), {31'b0, irq}, 32'h1);
            bus_wr(4'd2, 32'hFFFF_FFFF);
            bus_wr(4'd3, 32'hFFFF_FFFF);
            chk($sformatf("R4 irq after clear %0d", TBL[i].src), {31'b0, irq}, 32'h0);
        end

        // R5: disabled source stays silent until enabled
        bus_wr(4'd0, 32'h0);
        bus_wr(4'd1, 32'h0);
        pulse(40);
        chk("R5 disabled no irq", {31'b0, irq}, 32'h0);
        bus_rd(4'd4, d); chk("R5 disabled vector zero", d, 32'h0);
        bus_rd(4'd2, d); chk("R5 pending despite disable", d, 32'h1 << 23);
        bus_wr(4'd0, 32'h1 << 23);
        chk("R5 enabled irq", {31'b0, irq}, 32'h1);
        bus_rd(4'd4, d); chk("R5 enabled vector", d, {6'd40, 26'b0});

        // R6: lowest number wins; R4: writing zero keeps bits
        bus_wr(4'd0, 32'hFFFF_FFFF);
        pulse(33);
        bus_rd(4'd4, d); chk("R6 lowest of 33 and 40", d, {6'd33, 26'b0});
        bus_wr(4'd2, 32'h0);
        bus_rd(4'd2, d); chk("R4 zero write keeps", d, (32'h1 << 23) | (32'h1 << 30));
        // R11: reads have no side effects
        bus_rd(4'd4, d2);
        wait_clk(1);
        bus_rd(4'd4, d2);
        wait_clk(1);
        bus_rd(4'd4, d); chk("R11 vector stable over reads", d, {6'd33, 26'b0});
        bus_rd(4'd2, d); chk("R11 pending kept after reads", d, (32'h1 << 23) | (32'h1 << 30));
        bus_wr(4'd2, 32'h1 << 30);
        bus_rd(4'd4, d); chk("R4 R6 next source after clear", d, {6'd40, 26'b0});
        bus_wr(4'd2, 32'hFFFF_FFFF);

        // R12: only the shared bit enabled, source 31 requests
        bus_wr(4'd0, 32'h0);
        bus_wr(4'd1, 32'h1);
        pulse(31);
        bus_rd(4'd4, d); chk("R12 shared bit reports 18", d, {6'd18, 26'b0});
        bus_wr(4'd3, 32'hFFFF_FFFF);

        // R7 / R8: edge mode on external source 20 (sense bit 13, lower bit 13)
        bus_wr(4'd5, 32'h1 << 13);
        @(negedge clk); src_n[20] = 1'b0;
        wait_clk(5);
        bus_rd(4'd3, d); chk("R7 edge sets", d, 32'h1 << 13);
        bus_wr(4'd3, 32'h1 << 13);
        wait_clk(5);
        bus_rd(4'd3, d); chk("R7 R8 edge sets only once", d, 32'h0);
        src_n[20] = 1'b1;
        wait_clk(4);
        // R7: level mode on the same line re-sets after a clear
        bus_wr(4'd5, 32'h0);
        @(negedge clk); src_n[20] = 1'b0;
        wait_clk(5);
        bus_wr(4'd3, 32'h1 << 13);
        wait_clk(3);
        bus_rd(4'd3, d); chk("R7 level re-sets", d, 32'h1 << 13);
        src_n[20] = 1'b1;
        wait_clk(4);
        bus_wr(4'd3, 32'hFFFF_FFFF);

        // R8: port source 48 uses sense bit 31, external source 25 uses bit 8
        bus_wr(4'd5, (32'h1 << 31) | (32'h1 << 8));
        @(negedge clk); src_n[48] = 1'b0; src_n[25] = 1'b0;
        wait_clk(5);
        bus_wr(4'd3, 32'hFFFF_FFFF);
        wait_clk(5);
        bus_rd(4'd3, d); chk("R8 sources 48 and 25 edge only", d, 32'h0);
        src_n[48] = 1'b1; src_n[25] = 1'b1;
        wait_clk(4);
        // R7: second falling edge sets again
        @(negedge clk); src_n[48] = 1'b0;
        wait_clk(4);
        src_n[48] = 1'b1;
        wait_clk(4);
        bus_rd(4'd3, d); chk("R7 second edge sets", d, 32'h1 << 16);
        bus_wr(4'd3, 32'hFFFF_FFFF);

        // R9: fixed sources stay level with every sense bit set
        bus_wr(4'd5, 32'hFFFF_FFFF);
        @(negedge clk); src_n[16] = 1'b0; src_n[26] = 1'b0;
        wait_clk(5);
        bus_wr(4'd3, 32'hFFFF_FFFF);
        wait_clk(3);
        bus_rd(4'd3, d); chk("R9 fixed sources stay level", d, (32'h1 << 2) | (32'h1 << 7));
        src_n[16] = 1'b1; src_n[26] = 1'b1;
        wait_clk(4);
        bus_wr(4'd3, 32'hFFFF_FFFF);
        // R9: rising edge alone sets nothing
        @(negedge clk); src_n[50] = 1'b0;
        wait_clk(1);
        bus_wr(4'd3, 32'hFFFF_FFFF);
        wait_clk(5);
        bus_wr(4'd3, 32'hFFFF_FFFF);
        src_n[50] = 1'b1;
        wait_clk(5);
        bus_rd(4'd3, d); chk("R9 no rising edge response", d, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule